// File: doc/BRIEF.md
# Dual-Width Parallel Host Port

This block is the host-facing side of a character display controller. A host drives a register-select line, a read/write line and an enable strobe, plus an eight-bit data bus. The port brings the enable strobe into the internal clock domain and acts once per falling edge of it. Depending on the select and direction lines, a transfer either hands a command byte to the execution unit, stores a byte into the data register for writing to RAM, returns the busy flag with the address counter, or returns the prefetched byte held in the data register.

The bus runs as one eight-bit transfer or as two four-bit transfers on the upper four lines, upper half first. The width follows a mode bit that the port takes from every function-setting command as it passes through. The data register prefetches: after a host read, the port asks the execution unit to step the address and reload the register. The first read after a change of address without a reload therefore returns whatever the register held before.

Top module: `hb_host_port`

## Requirements
- R1: With select low and direction low, a completed transfer raises `cmd_stb` for one cycle with the byte on `cmd_byte`. With select high and direction low, the byte goes into the data register and `wr_stb` pulses for one cycle with that byte on `wr_byte`.
- R2: With select low and direction high, the read value is the busy input on bit 7 and the 7-bit address input on bits 6..0. This read raises no strobe, so the command register is never returned to the host.
- R3: With select high and direction high, the read value is the data register; `rd_adv` pulses once after the read completes. A `ram_load` pulse replaces the data register with `ram_byte`.
- R4: Transfers act only on a falling edge of `e_in`; a rising edge or a steady high level causes no strobe. Every strobe appears within eight clock cycles of the falling edge.
- R5: After reset the bus is eight bits wide. A command byte whose bits 7..5 are 001 sets the width from its bit 4: 1 gives eight bits, 0 gives four bits.
- R6: In four-bit mode each byte arrives as two transfers on `db_in[7:4]`, upper half first; bits 3..0 are ignored. The first half raises no strobe, and the second half raises the strobe for the assembled byte.
- R7: In four-bit mode a read also takes two transfers. The first shows bits 7..4 of the read value on `db_out[7:4]`, the second shows bits 3..0 there, and `db_out[3:0]` is zero. `rd_adv` follows only the second half of a data read.
- R8: The half-byte phase returns to the upper half at reset and whenever eight-bit mode is in force, so the next transfer after either one is whole or first-half.
- R9: `db_oe` is high only while the synchronised enable is high and direction is high; it is low during writes and while enable is low.
- R10: The data register clears at reset, so a data read with no load since reset returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| e_in | input | 1 | Host enable strobe, asynchronous |
| rs_in | input | 1 | Register select: 0 command/status, 1 data |
| rw_in | input | 1 | Direction: 1 read, 0 write |
| db_in | input | 8 | Host data bus, inbound |
| db_out | output | 8 | Host data bus, outbound |
| db_oe | output | 1 | Output enable for the host data bus |
| busy_in | input | 1 | Busy flag from the execution unit |
| ac_in | input | 7 | Address counter from the execution unit |
| ram_load | input | 1 | Execution unit loads the data register |
| ram_byte | input | 8 | Byte loaded into the data register |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Command byte |
| wr_stb | output | 1 | One-cycle RAM write strobe |
| wr_byte | output | 8 | Byte to store in RAM |
| rd_adv | output | 1 | One-cycle request to step the address and reload |

## Verification
A wrong half-byte phase shows at once: the next command arrives as a byte with its halves swapped or mixed with the previous transfer, or a strobe is missing after what the host treats as the second half. A stale width bit shows on the next transfer, as one strobe per half-byte or as no strobe at all. A data register that misses a host write or a load returns the wrong byte on the next data read, and a missing or doubled `rd_adv` is seen in the pulse count after each read.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int HB_DW = 8;
    localparam int HB_AW = HB_DW - 1;
    localparam int HB_NW = HB_DW / 2;

    typedef enum logic [1:0] {
        ACC_IR_WR   = 2'b00,
        ACC_STAT_RD = 2'b01,
        ACC_DR_WR   = 2'b10,
        ACC_DR_RD   = 2'b11
    } acc_e;

    typedef struct packed {
        acc_e              kind;
        logic [HB_DW-1:0]  data;
    } xfer_t;

    // Width-setting command: bits 7..5 = 001, width bit at 4
    function automatic logic is_width_cmd(input logic [HB_DW-1:0] b);
        return b[HB_DW-1:HB_DW-3] == 3'b001;
    endfunction

    function automatic logic [HB_DW-1:0] half_view(input logic [HB_DW-1:0] v,
                                                   input logic lower);
        return lower ? {v[HB_NW-1:0], {HB_NW{1'b0}}}
                     : {v[HB_DW-1:HB_NW], {HB_NW{1'b0}}};
    endfunction

endpackage

// File: rtl/hb_edge_sync.sv
module hb_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic e_async,
    output logic e_level,
    output logic e_fall
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= e_async;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 1'b0;
            else     chain[g] <= chain[g-1];
        end
    end

    assign e_level = chain[STAGES-1];
    assign e_fall  = chain[STAGES] & ~chain[STAGES-1];

    // R4: an edge is seen in one cycle only
    p_fall_single_r4: assert property (@(posedge clk) disable iff (rst)
        e_fall |=> !e_fall);

endmodule

// File: rtl/hb_nibble_pack.sv
module hb_nibble_pack
    import hb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic              rs,
    input  logic              rw,
    input  logic [HB_DW-1:0]  db,
    input  logic              wide,
    output logic              done,
    output xfer_t             xfer,
    output logic              phase
);
    logic [HB_NW-1:0] upper_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= 1'b0;
            upper_q <= '0;
            done    <= 1'b0;
            xfer    <= '0;
        end else begin
            done <= 1'b0;
            if (fall) begin
                xfer.kind <= acc_e'({rs, rw});
                if (wide) begin
                    done      <= 1'b1;
                    xfer.data <= db;
                    phase     <= 1'b0;
                end else if (!phase) begin
                    upper_q <= db[HB_DW-1:HB_NW];
                    phase   <= 1'b1;
                end else begin
                    done      <= 1'b1;
                    xfer.data <= {upper_q, db[HB_DW-1:HB_NW]};
                    phase     <= 1'b0;
                end
            end else if (wide) begin
                phase <= 1'b0;
            end
        end
    end

    // R6: the first half of a four-bit pair completes nothing
    p_first_half_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (fall && !wide && !phase) |=> !done);

endmodule

// File: rtl/hb_host_port.sv
module hb_host_port
    import hb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              e_in,
    input  logic              rs_in,
    input  logic              rw_in,
    input  logic [HB_DW-1:0]  db_in,
    output logic [HB_DW-1:0]  db_out,
    output logic              db_oe,
    input  logic              busy_in,
    input  logic [HB_AW-1:0]  ac_in,
    input  logic              ram_load,
    input  logic [HB_DW-1:0]  ram_byte,
    output logic              cmd_stb,
    output logic [HB_DW-1:0]  cmd_byte,
    output logic              wr_stb,
    output logic [HB_DW-1:0]  wr_byte,
    output logic              rd_adv
);
    logic        e_level, e_fall;
    logic        done, phase;
    xfer_t       xfer;
    logic        wide_q;
    logic [HB_DW-1:0] dr_q;
    logic        wr_stb_q, rd_adv_q;
    logic [HB_DW-1:0] rd_val;

    hb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .e_async (e_in),
        .e_level (e_level),
        .e_fall  (e_fall)
    );

    hb_nibble_pack u_pack (
        .clk   (clk),
        .rst   (rst),
        .fall  (e_fall),
        .rs    (rs_in),
        .rw    (rw_in),
        .db    (db_in),
        .wide  (wide_q),
        .done  (done),
        .xfer  (xfer),
        .phase (phase)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wide_q   <= 1'b1;
            dr_q     <= '0;
            wr_stb_q <= 1'b0;
            rd_adv_q <= 1'b0;
        end else begin
            wr_stb_q <= done && (xfer.kind == ACC_DR_WR);
            rd_adv_q <= done && (xfer.kind == ACC_DR_RD);
            if (done && xfer.kind == ACC_IR_WR && is_width_cmd(xfer.data))
                wide_q <= xfer.data[HB_DW-4];
            if (done && xfer.kind == ACC_DR_WR)
                dr_q <= xfer.data;
            else if (ram_load)
                dr_q <= ram_byte;
        end
    end

    assign rd_val   = rs_in ? dr_q : {busy_in, ac_in};
    assign db_out   = wide_q ? rd_val : half_view(rd_val, phase);
    assign db_oe    = e_level & rw_in;
    assign cmd_stb  = done && (xfer.kind == ACC_IR_WR);
    assign cmd_byte = xfer.data;
    assign wr_stb   = wr_stb_q;
    assign wr_byte  = dr_q;
    assign rd_adv   = rd_adv_q;

    // R1: at most one kind of action per cycle
    p_one_action_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_stb, wr_stb, rd_adv}));

    // R3: a completed host write lands in the data register
    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (done && xfer.kind == ACC_DR_WR) |=> (dr_q == $past(xfer.data)));

    // R5: eight-bit width right after reset
    p_default_wide_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> wide_q);

endmodule

// File: tb/hb_host_port_tb.sv
module hb_host_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       e_in = 1'b0, rs_in = 1'b0, rw_in = 1'b0;
    logic [7:0] db_in = 8'h00;
    logic [7:0] db_out;
    logic       db_oe;
    logic       busy_in = 1'b0;
    logic [6:0] ac_in = 7'h00;
    logic       ram_load = 1'b0;
    logic [7:0] ram_byte = 8'h00;
    logic       cmd_stb, wr_stb, rd_adv;
    logic [7:0] cmd_byte, wr_byte;

    int n_chk = 0, n_bad = 0;
    int n_cmd = 0, n_wr = 0, n_adv = 0;
    logic [7:0] last_cmd = 8'h00, last_wr = 8'h00;
    logic [7:0] seen;
    logic       seen_oe;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    hb_host_port u_dut (
        .clk(clk), .rst(rst), .e_in(e_in), .rs_in(rs_in), .rw_in(rw_in),
        .db_in(db_in), .db_out(db_out), .db_oe(db_oe), .busy_in(busy_in),
        .ac_in(ac_in), .ram_load(ram_load), .ram_byte(ram_byte),
        .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .wr_stb(wr_stb),
        .wr_byte(wr_byte), .rd_adv(rd_adv)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_stb) begin n_cmd <= n_cmd + 1; last_cmd <= cmd_byte; end
            if (wr_stb)  begin n_wr  <= n_wr + 1;  last_wr  <= wr_byte;  end
            if (rd_adv)  n_adv <= n_adv + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic rs, input logic rw, input logic [7:0] d);
        @(negedge clk);
        rs_in = rs; rw_in = rw; db_in = d;
        repeat (2) @(negedge clk);
        e_in = 1'b1;
        repeat (4) @(negedge clk);
        seen = db_out; seen_oe = db_oe;
        e_in = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // {rs, rw, bus byte, expected byte}
    localparam logic [17:0] VEC [8] = '{
        {1'b0, 1'b0, 8'h0C, 8'h0C},
        {1'b0, 1'b1, 8'h00, 8'hB5},
        {1'b1, 1'b0, 8'h41, 8'h41},
        {1'b1, 1'b1, 8'h00, 8'h41},
        {1'b1, 1'b0, 8'h7E, 8'h7E},
        {1'b0, 1'b0, 8'h80, 8'h80},
        {1'b1, 1'b1, 8'h00, 8'h7E},
        {1'b0, 1'b0, 8'h38, 8'h38}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int c0, w0, a0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset oe", db_oe, 0);
        check("R4 reset strobes", n_cmd + n_wr + n_adv, 0);

        // R10: data register is zero after reset
        bus_cycle(1'b1, 1'b1, 8'h00);
        check("R10 read after reset", seen, 8'h00);
        check("R9 oe during read", seen_oe, 1);
        check("R3 adv after read", n_adv, 1);

        busy_in = 1'b1; ac_in = 7'h35;
        for (int i = 0; i < 8; i++) begin
            c0 = n_cmd; w0 = n_wr; a0 = n_adv;
            bus_cycle(VEC[i][17], VEC[i][16], VEC[i][15:8]);
            case (VEC[i][17:16])
                2'b00: begin
                    check("R1 cmd count", n_cmd - c0, 1);
                    check("R1 cmd byte", last_cmd, VEC[i][7:0]);
                    check("R9 oe low on write", seen_oe, 0);
                end
                2'b01: begin
                    check("R2 status", seen, VEC[i][7:0]);
                    check("R2 no strobe", (n_cmd - c0) + (n_wr - w0) + (n_adv - a0), 0);
                end
                2'b10: begin
                    check("R1 wr count", n_wr - w0, 1);
                    check("R1 wr byte", last_wr, VEC[i][7:0]);
                end
                default: begin
                    check("R3 data read", seen, VEC[i][7:0]);
                    check("R3 adv count", n_adv - a0, 1);
                end
            endcase
        end

        // R4: rising edge and steady high do nothing
        c0 = n_cmd;
        @(negedge clk); rs_in = 1'b0; rw_in = 1'b0; db_in = 8'h99;
        repeat (2) @(negedge clk); e_in = 1'b1;
        repeat (10) @(negedge clk);
        check("R4 no strobe while high", n_cmd - c0, 0);
        e_in = 1'b0;
        repeat (8) @(negedge clk);
        check("R4 strobe after fall", n_cmd - c0, 1);
        check("R4 byte after fall", last_cmd, 8'h99);
        check("R9 oe after fall", db_oe, 0);

        // R3: load replaces the data register
        @(negedge clk); ram_load = 1'b1; ram_byte = 8'h5A;
        @(negedge clk); ram_load = 1'b0;
        bus_cycle(1'b1, 1'b1, 8'h00);
        check("R3 loaded read", seen, 8'h5A);

        // R5: select four-bit width
        bus_cycle(1'b0, 1'b0, 8'h28);
        check("R5 width cmd", last_cmd, 8'h28);

        // R6: command as two halves, low lines junk
        c0 = n_cmd;
        bus_cycle(1'b0, 1'b0, 8'h09);
        check("R6 no strobe first half", n_cmd - c0, 0);
        bus_cycle(1'b0, 1'b0, 8'hF6);
        check("R6 strobe second half", n_cmd - c0, 1);
        check("R6 assembled cmd", last_cmd, 8'h0F);

        w0 = n_wr;
        bus_cycle(1'b1, 1'b0, 8'hA3);
        bus_cycle(1'b1, 1'b0, 8'h5C);
        check("R6 wr count", n_wr - w0, 1);
        check("R6 wr byte", last_wr, 8'hA5);

        // R7: status read in halves
        busy_in = 1'b0; ac_in = 7'h2C;
        c0 = n_cmd; a0 = n_adv;
        bus_cycle(1'b0, 1'b1, 8'h00);
        check("R7 status upper", seen, 8'h20);
        bus_cycle(1'b0, 1'b1, 8'h00);
        check("R7 status lower", seen, 8'hC0);
        check("R7 status no strobe", (n_cmd - c0) + (n_adv - a0), 0);

        // R7: data read in halves
        a0 = n_adv;
        bus_cycle(1'b1, 1'b1, 8'h00);
        check("R7 data upper", seen, 8'hA0);
        check("R7 no adv first half", n_adv - a0, 0);
        bus_cycle(1'b1, 1'b1, 8'h00);
        check("R7 data lower", seen, 8'h50);
        check("R7 adv after second", n_adv - a0, 1);

        // R8/R5: back to eight bits, next byte whole
        bus_cycle(1'b0, 1'b0, 8'h30);
        bus_cycle(1'b0, 1'b0, 8'h00);
        check("R5 wide cmd", last_cmd, 8'h30);
        c0 = n_cmd;
        bus_cycle(1'b0, 1'b0, 8'h01);
        check("R8 whole byte count", n_cmd - c0, 1);
        check("R8 whole byte", last_cmd, 8'h01);

        // R8/R5: reset mid-pair
        bus_cycle(1'b0, 1'b0, 8'h20);
        bus_cycle(1'b0, 1'b0, 8'h80);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        c0 = n_cmd;
        bus_cycle(1'b0, 1'b0, 8'h33);
        check("R8 reset clears phase count", n_cmd - c0, 1);
        check("R5 reset width byte", last_cmd, 8'h33);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule